// File: doc/BRIEF.md
# MMU and Cache Control Register File

This block is the software-visible control and status register file that sits beside a processor's address translation unit and caches. It decodes word accesses in a small control region and stores the page-table entry words, the translation table base, the fault address, the trap and exception codes and the cache and queue control words. It does not contain the TLB, the cache arrays or any exception logic. It only drives the control outputs those units consume.

Writes to some registers have side effects. The TLB-invalidate command bit of the MMU control word does not stay set: writing it as 1 produces a TLB flush pulse. Flipping the translation-enable bit produces a mode-change pulse, which the caches use as a reset request. Writing a new address-space ID into the page-table-entry-high word produces a translation flush pulse. The two cache-invalidate command bits are dropped when the word is stored. The two queue control words each carry an area field, and the block turns that field into a store-queue base address.

An access is a single cycle with `acc_en` high, and `acc_we` selects a write. Read data is combinational on the same cycle and shows the stored value before any write in that cycle.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset, every mapped register reads 0 except the version word, all pulse outputs are low, `xlat_en_o` is 0, and both store-queue bases and `cache_ctrl_o` are 0.
- R2: The 32-bit words at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x20, 0x24, 0x28, 0x34, 0x38 and 0x3C read back the last value written. Offset bits [1:0] are ignored, and `acc_rdata` is 0 in any cycle that is not a read.
- R3: The break-select words at offsets 0x14 and 0x18 keep only write-data bits [7:0] and read back zero-extended.
- R4: A write to the MMU control word at 0x10 with bit 2 (TLB invalidate) set raises `tlb_flush_o` in that same cycle. Bit 2 is stored as 0.
- R5: A write to 0x10 whose bit 0 (translation enable) differs from the stored bit raises `xlat_chg_o` in that same cycle, and `xlat_en_o` shows the new bit from the next cycle. A write that leaves bit 0 unchanged raises no pulse.
- R6: A write to 0x00 whose bits [7:0] (address-space ID) differ from the stored ID raises `asid_flush_o` in that same cycle. A write with an equal ID raises no pulse.
- R7: The cache control word at 0x1C stores the write data with bits 11 and 3 forced to 0. `cache_ctrl_o` mirrors the stored word.
- R8: Offset 0x30 reads the constant 0x040205C1 and offset 0x44 reads 0. Writes to either have no effect.
- R9: Unmapped offsets (0x2C, 0x40 and 0x48 to 0xFC) read 0, and writes to them change no register.
- R10: Each queue control word (0x38 for queue 0, 0x3C for queue 1) has an area field in bits [4:2]. From the cycle after the write, the matching `sq_baseN_o` equals that field shifted left by 26, with all other bits 0.
- R11: No pulse output rises in a cycle without a write, or on a write to another offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_off | input | 8 | Byte offset inside the control region |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle |
| tlb_flush_o | output | 1 | TLB flush pulse |
| asid_flush_o | output | 1 | Address-space change flush pulse |
| xlat_chg_o | output | 1 | Translation mode change / cache reset pulse |
| xlat_en_o | output | 1 | Stored translation-enable bit |
| cache_ctrl_o | output | 32 | Stored cache control word |
| sq_base0_o | output | 32 | Store-queue 0 base address |
| sq_base1_o | output | 32 | Store-queue 1 base address |

## Verification
The TLB-invalidate command and the translation-enable change can both happen in one MMU control write, so both pulses can fall in the same cycle. The bench provokes this with directed writes that set bit 2 while toggling bit 0, and with random writes of arbitrary data to offset 0x10. For each write it predicts both pulses separately: the TLB flush pulse from the written bit 2, and the mode-change pulse by comparing the written bit 0 against its own model of the stored bit. It then checks that the stored command bit reads back as 0 in the following cycles.

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs #(
  parameter int          OFF_W      = 8,
  parameter logic [31:0] VERSION_ID = 32'h040205C1,
  parameter int          ASID_W     = 8,
  parameter int          AREA_LSB   = 2,
  parameter int          AREA_W     = 3,
  parameter int          SQ_SHIFT   = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [31:0]      acc_wdata,
  output logic [31:0]      acc_rdata,
  output logic             tlb_flush_o,
  output logic             asid_flush_o,
  output logic             xlat_chg_o,
  output logic             xlat_en_o,
  output logic [31:0]      cache_ctrl_o,
  output logic [31:0]      sq_base0_o,
  output logic [31:0]      sq_base1_o
);

  localparam int IDX_W = OFF_W - 2;
  localparam logic [IDX_W-1:0] I_PTEH  = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_PTEL  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_TTB   = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_FAULT = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_MMU   = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_BRKA  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_BRKB  = IDX_W'(6);
  localparam logic [IDX_W-1:0] I_CACHE = IDX_W'(7);
  localparam logic [IDX_W-1:0] I_TRAP  = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_EXC   = IDX_W'(9);
  localparam logic [IDX_W-1:0] I_IRQ   = IDX_W'(10);
  localparam logic [IDX_W-1:0] I_VER   = IDX_W'(12);
  localparam logic [IDX_W-1:0] I_PTEA  = IDX_W'(13);
  localparam logic [IDX_W-1:0] I_QAC0  = IDX_W'(14);
  localparam logic [IDX_W-1:0] I_QAC1  = IDX_W'(15);
  localparam int XLAT_BIT   = 0;
  localparam int TLBINV_BIT = 2;
  localparam logic [31:0] CACHE_CMD_MASK = 32'h0000_0808;
  localparam logic [31:0] MMU_CMD_MASK   = 32'h1 << TLBINV_BIT;

  logic [31:0] pte_hi, pte_lo, tt_base, fault_addr, mmu_ctl, cache_ctl;
  logic [31:0] trap_code, exc_evt, irq_evt, pte_assist;
  logic [7:0]  brk_a, brk_b;
  logic [31:0] qac [2];

  wire             wr   = acc_en & acc_we;
  wire             rd   = acc_en & ~acc_we;
  wire [IDX_W-1:0] widx = acc_off[OFF_W-1:2];

  assign tlb_flush_o  = wr && widx == I_MMU && acc_wdata[TLBINV_BIT];
  assign xlat_chg_o   = wr && widx == I_MMU && (acc_wdata[XLAT_BIT] != mmu_ctl[XLAT_BIT]);
  assign asid_flush_o = wr && widx == I_PTEH && (acc_wdata[ASID_W-1:0] != pte_hi[ASID_W-1:0]);

  assign xlat_en_o    = mmu_ctl[XLAT_BIT];
  assign cache_ctrl_o = cache_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pte_hi     <= '0;
      pte_lo     <= '0;
      tt_base    <= '0;
      fault_addr <= '0;
      mmu_ctl    <= '0;
      cache_ctl  <= '0;
      trap_code  <= '0;
      exc_evt    <= '0;
      irq_evt    <= '0;
      pte_assist <= '0;
      brk_a      <= '0;
      brk_b      <= '0;
    end else if (wr) begin
      case (widx)
        I_PTEH:  pte_hi     <= acc_wdata;
        I_PTEL:  pte_lo     <= acc_wdata;
        I_TTB:   tt_base    <= acc_wdata;
        I_FAULT: fault_addr <= acc_wdata;
        I_MMU:   mmu_ctl    <= acc_wdata & ~MMU_CMD_MASK;
        I_BRKA:  brk_a      <= acc_wdata[7:0];
        I_BRKB:  brk_b      <= acc_wdata[7:0];
        I_CACHE: cache_ctl  <= acc_wdata & ~CACHE_CMD_MASK;
        I_TRAP:  trap_code  <= acc_wdata;
        I_EXC:   exc_evt    <= acc_wdata;
        I_IRQ:   irq_evt    <= acc_wdata;
        I_PTEA:  pte_assist <= acc_wdata;
        default: ;
      endcase
    end
  end

  for (genvar q = 0; q < 2; q++) begin : g_queue
    wire [IDX_W-1:0] my_idx = (q == 0) ? I_QAC0 : I_QAC1;
    always_ff @(posedge clk) begin
      if (!rst_n)                    qac[q] <= '0;
      else if (wr && widx == my_idx) qac[q] <= acc_wdata;
    end
  end

  assign sq_base0_o = 32'(qac[0][AREA_LSB +: AREA_W]) << SQ_SHIFT;
  assign sq_base1_o = 32'(qac[1][AREA_LSB +: AREA_W]) << SQ_SHIFT;

  always_comb begin
    acc_rdata = '0;
    if (rd) begin
      case (widx)
        I_PTEH:  acc_rdata = pte_hi;
        I_PTEL:  acc_rdata = pte_lo;
        I_TTB:   acc_rdata = tt_base;
        I_FAULT: acc_rdata = fault_addr;
        I_MMU:   acc_rdata = mmu_ctl;
        I_BRKA:  acc_rdata = {24'b0, brk_a};
        I_BRKB:  acc_rdata = {24'b0, brk_b};
        I_CACHE: acc_rdata = cache_ctl;
        I_TRAP:  acc_rdata = trap_code;
        I_EXC:   acc_rdata = exc_evt;
        I_IRQ:   acc_rdata = irq_evt;
        I_VER:   acc_rdata = VERSION_ID;
        I_PTEA:  acc_rdata = pte_assist;
        I_QAC0:  acc_rdata = qac[0];
        I_QAC1:  acc_rdata = qac[1];
        default: acc_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mmu_ctl_regs_chk.sv
module mmu_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_en,
  input logic        acc_we,
  input logic [7:0]  acc_off,
  input logic [31:0] acc_wdata,
  input logic        tlb_flush_o,
  input logic        asid_flush_o,
  input logic        xlat_chg_o,
  input logic        xlat_en_o,
  input logic [31:0] cache_ctrl_o,
  input logic [31:0] sq_base0_o,
  input logic [31:0] sq_base1_o,
  input logic [31:0] pte_hi,
  input logic [31:0] mmu_ctl
);
  wire       wr   = acc_en & acc_we;
  wire [5:0] widx = acc_off[7:2];

  a_r4_tlb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 6'd4 && acc_wdata[2]) |-> tlb_flush_o);

  a_r4_cmd_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |=> !mmu_ctl[2]);

  a_r5_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_chg_o |=> (xlat_en_o != $past(xlat_en_o)));

  a_r5_mode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !xlat_chg_o |=> $stable(xlat_en_o));

  a_r6_asid_moves: assert property (@(posedge clk) disable iff (!rst_n)
    asid_flush_o |=> (pte_hi[7:0] != $past(pte_hi[7:0])));

  a_r7_cache_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 6'd7) |=> cache_ctrl_o == ($past(acc_wdata) & ~32'h0000_0808));

  a_r10_queue0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 6'd14) |=> sq_base0_o == {3'b0, $past(acc_wdata[4:2]), 26'b0});

  a_r10_queue1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && widx == 6'd15) |=> sq_base1_o == {3'b0, $past(acc_wdata[4:2]), 26'b0});

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |-> !(tlb_flush_o || asid_flush_o || xlat_chg_o));

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({asid_flush_o, tlb_flush_o}));
endmodule

bind mmu_ctl_regs mmu_ctl_regs_chk u_chk (.*);

// File: tb/mmu_ctl_regs_tb.sv
`timescale 1ns/1ps
module mmu_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [7:0]  acc_off = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata, cache_ctrl_o, sq_base0_o, sq_base1_o;
  logic        tlb_flush_o, asid_flush_o, xlat_chg_o, xlat_en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m [64];

  always #2.5 clk = ~clk;

  mmu_ctl_regs u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(int i);
    case (i)
      0,1,2,3,4,7,8,9,10,13,14,15: return m[i];
      5,6:  return {24'b0, m[i][7:0]};
      12:   return 32'h040205C1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(int i);
    case (i)
      5,6:   return "R3";
      4:     return "R4";
      7:     return "R7";
      12,17: return "R8";
      0,1,2,3,8,9,10,13,14,15: return "R2";
      default: return "R9";
    endcase
  endfunction

  function automatic void model_write(int i, logic [31:0] d);
    case (i)
      0,1,2,3,8,9,10,13,14,15: m[i] = d;
      4: m[i] = d & ~32'h4;
      5,6: m[i] = {24'b0, d[7:0]};
      7: m[i] = d & ~32'h808;
      default: ;
    endcase
  endfunction

  function automatic logic [31:0] sq_of(logic [31:0] q);
    return {3'b0, q[4:2], 26'b0};
  endfunction

  task automatic access(bit we, logic [7:0] off, logic [31:0] d);
    int i = int'(off[7:2]);
    @(negedge clk);
    acc_en = 1'b1; acc_we = we; acc_off = off; acc_wdata = d;
    #1;
    chk(we ? "R2" : tag_of(i), acc_rdata, we ? 32'h0 : exp_read(i));
    chk("R4/R11 tlb", {31'b0, tlb_flush_o}, {31'b0, we && i == 4 && d[2]});
    chk("R5/R11 mode", {31'b0, xlat_chg_o}, {31'b0, we && i == 4 && (d[0] != m[4][0])});
    chk("R6/R11 asid", {31'b0, asid_flush_o}, {31'b0, we && i == 0 && (d[7:0] != m[0][7:0])});
    @(posedge clk);
    if (we) model_write(i, d);
    #1;
    acc_en = 1'b0;
    chk("R5 xlat_en", {31'b0, xlat_en_o}, {31'b0, m[4][0]});
    chk("R7 cache_ctrl", cache_ctrl_o, m[7]);
    chk("R10 sq0", sq_base0_o, sq_of(m[14]));
    chk("R10 sq1", sq_base1_o, sq_of(m[15]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    foreach (m[k]) m[k] = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 pulses", {29'b0, tlb_flush_o, asid_flush_o, xlat_chg_o}, 32'h0);
    chk("R1 sq0", sq_base0_o, 32'h0);
    chk("R1 sq1", sq_base1_o, 32'h0);
    chk("R1 cache", cache_ctrl_o, 32'h0);
    chk("R1 xlat", {31'b0, xlat_en_o}, 32'h0);
    for (int o = 0; o < 64; o++) access(1'b0, 8'(o * 4), 32'h0);

    // R4 + R5 in one write, then R5 unchanged, R4 alone
    access(1'b1, 8'h10, 32'h0000_0005);
    access(1'b0, 8'h10, 32'h0);
    access(1'b1, 8'h10, 32'h0000_0001);
    access(1'b1, 8'h10, 32'h0000_0105);
    access(1'b1, 8'h10, 32'h0000_0004);
    // R6: same ID, then new ID
    access(1'b1, 8'h00, 32'hABCD_0000);
    access(1'b1, 8'h00, 32'hABCD_0042);
    access(1'b1, 8'h01, 32'h1111_1142);
    access(1'b0, 8'h02, 32'h0);
    // R7
    access(1'b1, 8'h1C, 32'hFFFF_FFFF);
    access(1'b0, 8'h1C, 32'h0);
    // R3
    access(1'b1, 8'h14, 32'hDEAD_BEA5);
    access(1'b0, 8'h14, 32'h0);
    // R8 and R9: writes ignored
    access(1'b1, 8'h30, 32'h1234_5678);
    access(1'b1, 8'h44, 32'hFFFF_FFFF);
    access(1'b1, 8'h2C, 32'hFFFF_FFFF);
    access(1'b1, 8'h40, 32'hFFFF_FFFF);
    access(1'b0, 8'h30, 32'h0);
    access(1'b0, 8'h44, 32'h0);
    access(1'b0, 8'h2C, 32'h0);
    // R10 extremes
    access(1'b1, 8'h38, 32'hFFFF_FFFC);
    access(1'b1, 8'h3C, 32'h0000_0010);
    access(1'b1, 8'h38, 32'hFFFF_FFE3);

    for (int n = 0; n < 4000; n++) begin
      bit we = $urandom_range(0, 1) == 1;
      logic [7:0] off = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255))
                                                    : 8'($urandom_range(0, 17) * 4);
      logic [31:0] d = $urandom();
      if (off[7:2] == 6'd0 && $urandom_range(0, 1) == 1) d[7:0] = m[0][7:0];
      access(we, off, d);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule